// File: doc/BRIEF.md
# Single-Bus Microcoded Processor Datapath

This block is the data side of a small microprogrammed 32-bit processor. Every transfer goes over one shared bus. An outside sequencer presents one microinstruction per cycle. A microinstruction picks at most one source to drive the bus: the immediate generator, the ALU, the register file or memory. It also names any number of destinations that capture the bus value at the next rising clock edge. Those destinations are the instruction register, the two operand latches A and B, the memory address register, the selected register-file entry and memory itself.

The register file holds 32 general registers and one extra entry that serves as the program counter. All of them are addressed through one selector. That selector takes a register index from the instruction register, or it names the link register or the program counter directly. The block returns three status signals to the sequencer: the opcode of the held instruction, an equality flag on A and B, and the memory busy signal passed straight through. A microcode step such as "MA, A ← PC" therefore takes one cycle, and the same holds for "PC ← A + 4" and "A ← A − 4".

Top module: `ubus_datapath`

## Requirements
- R1: Synchronous active-high reset clears the instruction register, A, B, the memory address register, all general registers and the program-counter entry to zero.
- R2: The bus carries the value of the one enabled source. If no source is enabled, the bus carries zero. Memory counts as a source only when `mem_oe`=1 and `mem_wr`=0. The bus value always appears on `mem_wdata`.
- R3: At a rising edge, each of `ld_ir`, `ld_a`, `ld_b` and `ld_ma` that is high loads its register from the bus, in any combination. Registers whose load is low keep their value. `mem_addr` shows the memory address register.
- R4: `reg_sel` picks the register-file entry for both read and write. The codes are: 0 = rs1 (IR[26:22]), 1 = rs2 (IR[21:17]), 2 = rd (IR[31:27]), 3 = entry 1 (link), 4 = entry 32 (program counter), 5 to 7 = entry 0. When `reg_wr`=1, the bus is written into that entry at the edge.
- R5: Entry 0 always reads as zero, and writes to it have no effect.
- R6: `imm_sel` picks the immediate. The value is sign-extended to 32 bits in every case. 0 = IR[21:10]. 1 = {IR[31:27], IR[16:10]}. 2 = {IR[31:7], 0}. 3 = {IR[31:27], IR[16:10], 0}.
- R7: `alu_op` codes: 0 = A, 1 = A+B, 2 = A−4, 3 = A+4, 4 = the function in IR[9:7], 5 = B, 6 and 7 = zero. The IR[9:7] function codes are: 0 add, 1 subtract A−B, 2 and, 3 or, 4 xor, 5 signed less-than (0/1), 6 shift A left by B[4:0], 7 logical shift A right by B[4:0].
- R8: `zero` is high exactly when A equals B.
- R9: `opcode` shows IR[6:0], and `busy` follows `mem_busy`.
- R10: `mem_re` = `mem_oe` and not `mem_wr`. `mem_we` = `mem_oe` and `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_a | input | 1 | Load operand A from bus |
| ld_b | input | 1 | Load operand B from bus |
| ld_ma | input | 1 | Load memory address register from bus |
| reg_sel | input | 3 | Register-file entry selector |
| reg_wr | input | 1 | Write bus into selected entry |
| reg_oe | input | 1 | Register file drives bus |
| imm_sel | input | 2 | Immediate format selector |
| imm_oe | input | 1 | Immediate generator drives bus |
| alu_op | input | 3 | ALU operation |
| alu_oe | input | 1 | ALU drives bus |
| mem_wr | input | 1 | Memory direction: 1 write, 0 read |
| mem_oe | input | 1 | Memory access enable |
| mem_rdata | input | 32 | Read data from memory |
| mem_busy | input | 1 | Memory busy |
| mem_addr | output | 32 | Memory address register |
| mem_wdata | output | 32 | Bus value, write data to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| busy | output | 1 | Busy status to sequencer |
| zero | output | 1 | A equals B |
| opcode | output | 7 | Opcode field of the instruction register |

## Verification
Two functions can fall in the same cycle. The first is a read of a register-file entry or operand latch. The second is a write of that same storage from the bus value that read produced. Examples are "PC ← A + 4" with the program-counter entry both selected and written, "A ← A − 4" with A as both ALU source and destination, and "MA, A ← PC" loading two latches at once. The bench provokes these directly and also through several hundred random microinstructions with at most one bus driver. A behavioural model applies old-value reads and edge-time writes, and on every cycle the bus, address, flag and opcode outputs are compared against it.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
  localparam int ILEN    = 32;
  localparam int REGF_W  = 5;
  localparam int RD_LSB  = 27;
  localparam int RS1_LSB = 22;
  localparam int RS2_LSB = 17;
  localparam int FN_LSB  = 7;
  localparam int OPC_W   = 7;
  localparam int IHI_LSB = 7;   // immediate generator sees IR[31:7]
  localparam int IHI_W   = ILEN - IHI_LSB;

  typedef enum logic [2:0] {
    RS_RS1 = 3'd0, RS_RS2 = 3'd1, RS_RD = 3'd2, RS_LINK = 3'd3, RS_PC = 3'd4
  } rsel_e;

  typedef enum logic [1:0] {
    IMM_I = 2'd0, IMM_S = 2'd1, IMM_J = 2'd2, IMM_B = 2'd3
  } imm_e;

  typedef enum logic [2:0] {
    ALU_PASS_A = 3'd0, ALU_ADD = 3'd1, ALU_SUB4 = 3'd2, ALU_ADD4 = 3'd3,
    ALU_FUNC   = 3'd4, ALU_PASS_B = 3'd5
  } alu_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2, FN_OR = 3'd3,
    FN_XOR = 3'd4, FN_SLT = 3'd5, FN_SLL = 3'd6, FN_SRL = 3'd7
  } fn_e;
endpackage

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
  parameter int DATA_W = 32,
  parameter int NGPR   = 32,
  localparam int DEPTH = NGPR + 1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  // general registers plus the program counter in the last entry
  logic [DATA_W-1:0] regs [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr && idx != '0) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = (idx == '0) ? '0 : regs[idx];
endmodule

// File: rtl/ubus_immgen.sv
module ubus_immgen import ubus_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [IHI_W-1:0]  ir_hi,   // IR[31:7]; bit k of IR is ir_hi[k-7]
  input  imm_e              sel,
  output logic [DATA_W-1:0] imm
);
  logic [11:0] split12;
  assign split12 = {ir_hi[24:20], ir_hi[9:3]};

  always_comb begin
    case (sel)
      IMM_I:   imm = DATA_W'($signed(ir_hi[14:3]));
      IMM_S:   imm = DATA_W'($signed(split12));
      IMM_J:   imm = DATA_W'($signed({ir_hi, 1'b0}));
      default: imm = DATA_W'($signed({split12, 1'b0}));
    endcase
  end
endmodule

// File: rtl/ubus_alu.sv
module ubus_alu import ubus_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  alu_e              op,
  input  fn_e               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] fres;

  always_comb begin
    case (fn)
      FN_ADD:  fres = a + b;
      FN_SUB:  fres = a - b;
      FN_AND:  fres = a & b;
      FN_OR:   fres = a | b;
      FN_XOR:  fres = a ^ b;
      FN_SLT:  fres = {{(DATA_W-1){1'b0}}, $signed(a) < $signed(b)};
      FN_SLL:  fres = a << b[SHW-1:0];
      default: fres = a >> b[SHW-1:0];
    endcase
  end

  always_comb begin
    case (op)
      ALU_PASS_A: y = a;
      ALU_ADD:    y = a + b;
      ALU_SUB4:   y = a - DATA_W'(4);
      ALU_ADD4:   y = a + DATA_W'(4);
      ALU_FUNC:   y = fres;
      ALU_PASS_B: y = b;
      default:    y = '0;
    endcase
  end
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath import ubus_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int NGPR   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_ir,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_ma,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_oe,
  input  logic [1:0]        imm_sel,
  input  logic              imm_oe,
  input  logic [2:0]        alu_op,
  input  logic              alu_oe,
  input  logic              mem_wr,
  input  logic              mem_oe,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_busy,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              busy,
  output logic              zero,
  output logic [OPC_W-1:0]  opcode
);
  localparam int AW       = $clog2(NGPR + 1);
  localparam int PC_IDX   = NGPR;
  localparam int LINK_IDX = 1;

  logic [ILEN-1:0]   ir_q;
  logic [DATA_W-1:0] a_q, b_q, ma_q;
  logic [DATA_W-1:0] bus, imm, alu_y, rf_rd;
  logic [AW-1:0]     rf_idx;

  // register-file port selection
  always_comb begin
    case (rsel_e'(reg_sel))
      RS_RS1:  rf_idx = AW'(ir_q[RS1_LSB +: REGF_W]);
      RS_RS2:  rf_idx = AW'(ir_q[RS2_LSB +: REGF_W]);
      RS_RD:   rf_idx = AW'(ir_q[RD_LSB  +: REGF_W]);
      RS_LINK: rf_idx = AW'(LINK_IDX);
      RS_PC:   rf_idx = AW'(PC_IDX);
      default: rf_idx = '0;
    endcase
  end

  ubus_regfile #(.DATA_W(DATA_W), .NGPR(NGPR)) u_rf (
    .clk(clk), .rst(rst), .idx(rf_idx), .wr(reg_wr), .wdata(bus), .rdata(rf_rd)
  );

  ubus_immgen #(.DATA_W(DATA_W)) u_imm (
    .ir_hi(ir_q[ILEN-1:IHI_LSB]), .sel(imm_e'(imm_sel)), .imm(imm)
  );

  ubus_alu #(.DATA_W(DATA_W)) u_alu (
    .op(alu_e'(alu_op)), .fn(fn_e'(ir_q[FN_LSB +: 3])), .a(a_q), .b(b_q), .y(alu_y)
  );

  assign mem_re = mem_oe & ~mem_wr;
  assign mem_we = mem_oe & mem_wr;

  // shared bus: one driver expected per cycle
  always_comb begin
    bus = '0;
    if (imm_oe)      bus = imm;
    else if (alu_oe) bus = alu_y;
    else if (reg_oe) bus = rf_rd;
    else if (mem_re) bus = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus[ILEN-1:0];
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
    end
  end

  assign mem_addr  = ma_q;
  assign mem_wdata = bus;
  assign busy      = mem_busy;
  assign zero      = (a_q == b_q);
  assign opcode    = ir_q[OPC_W-1:0];
endmodule

// File: rtl/ubus_datapath_chk.sv
module ubus_datapath_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_ir,
  input logic              ld_a,
  input logic              ld_b,
  input logic              ld_ma,
  input logic              reg_oe,
  input logic              imm_oe,
  input logic              alu_oe,
  input logic              mem_wr,
  input logic              mem_oe,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              zero,
  input logic [6:0]        opcode
);
  // R2
  bus_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({imm_oe, alu_oe, reg_oe, mem_oe && !mem_wr}));
  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !(imm_oe || alu_oe || reg_oe || (mem_oe && !mem_wr)) |-> mem_wdata == '0);
  // R3
  ma_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ma |=> mem_addr == $past(mem_wdata));
  // R3
  ma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_ma |=> $stable(mem_addr));
  // R9
  ir_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> opcode == $past(mem_wdata[6:0]));
  // R8
  zero_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a && ld_b) |=> zero);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_addr == '0 && opcode == '0 && zero));
endmodule

bind ubus_datapath ubus_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
  .reg_oe(reg_oe), .imm_oe(imm_oe), .alu_oe(alu_oe), .mem_wr(mem_wr),
  .mem_oe(mem_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .zero(zero),
  .opcode(opcode)
);

// File: tb/ubus_datapath_tb.sv
module ubus_datapath_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0;
  logic [2:0] reg_sel = '0;
  logic reg_wr = 0, reg_oe = 0;
  logic [1:0] imm_sel = '0;
  logic imm_oe = 0;
  logic [2:0] alu_op = '0;
  logic alu_oe = 0, mem_wr = 0, mem_oe = 0;
  logic [31:0] mem_rdata = '0;
  logic mem_busy = 0;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_we, mem_re, busy, zero;
  logic [6:0] opcode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_rf [0:32];
  logic [31:0] m_ir, m_a, m_b, m_ma;

  always #(CLK_P/2) clk = ~clk;

  ubus_datapath dut_i (
    .clk(clk), .rst(rst), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_oe(reg_oe), .imm_sel(imm_sel),
    .imm_oe(imm_oe), .alu_op(alu_op), .alu_oe(alu_oe), .mem_wr(mem_wr),
    .mem_oe(mem_oe), .mem_rdata(mem_rdata), .mem_busy(mem_busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .busy(busy), .zero(zero), .opcode(opcode)
  );

  function automatic logic [31:0] enc(input int rd, input int rs1, input int rs2,
                                      input int lo7, input int fn, input int op);
    return {rd[4:0], rs1[4:0], rs2[4:0], lo7[6:0], fn[2:0], op[6:0]};
  endfunction

  function automatic logic [31:0] sx(input logic [31:0] v, input int w);
    logic [31:0] t;
    t = v << (32 - w);
    return 32'($signed(t) >>> (32 - w));
  endfunction

  function automatic logic [31:0] m_imm(input int sel);
    logic [31:0] s12;
    s12 = sx({20'b0, m_ir[31:27], m_ir[16:10]}, 12);
    case (sel)
      0:       return sx({20'b0, m_ir[21:10]}, 12);
      1:       return s12;
      2:       return sx({7'b0, m_ir[31:7]}, 25) << 1;
      default: return s12 << 1;
    endcase
  endfunction

  function automatic logic [31:0] m_alu(input int op);
    logic [31:0] r;
    case (m_ir[9:7])
      3'd0: r = m_a + m_b;
      3'd1: r = m_a - m_b;
      3'd2: r = m_a & m_b;
      3'd3: r = m_a | m_b;
      3'd4: r = m_a ^ m_b;
      3'd5: r = ($signed(m_a) < $signed(m_b)) ? 32'd1 : 32'd0;
      3'd6: r = m_a << m_b[4:0];
      default: r = m_a >> m_b[4:0];
    endcase
    case (op)
      0: return m_a;
      1: return m_a + m_b;
      2: return m_a - 32'd4;
      3: return m_a + 32'd4;
      4: return r;
      5: return m_b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic int m_idx(input int sel);
    case (sel)
      0: return int'(m_ir[26:22]);
      1: return int'(m_ir[21:17]);
      2: return int'(m_ir[31:27]);
      3: return 1;
      4: return 32;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // drv: 0 none, 1 immediate, 2 ALU, 3 register file, 4 memory read
  task automatic step(input string tag, input int drv,
                      input bit lir, input bit la, input bit lb, input bit lma,
                      input int rsel, input bit rwr, input int isel, input int aop,
                      input bit mw, input logic [31:0] rdat);
    logic [31:0] exp_bus;
    int idx;
    @(negedge clk);
    ld_ir = lir; ld_a = la; ld_b = lb; ld_ma = lma;
    reg_sel = rsel[2:0]; reg_wr = rwr; imm_sel = isel[1:0]; alu_op = aop[2:0];
    imm_oe = (drv == 1); alu_oe = (drv == 2); reg_oe = (drv == 3);
    mem_oe = (drv == 4) || mw; mem_wr = (drv != 4) && mw;
    mem_rdata = rdat; mem_busy = 1'($urandom);
    #1;
    idx = m_idx(rsel);
    case (drv)
      1: exp_bus = m_imm(isel);
      2: exp_bus = m_alu(aop);
      3: exp_bus = (idx == 0) ? 32'd0 : m_rf[idx];
      4: exp_bus = rdat;
      default: exp_bus = 32'd0;
    endcase
    chk(tag, "bus", mem_wdata, exp_bus);
    chk("R3", "mem_addr", mem_addr, m_ma);
    chk("R8", "zero", {31'b0, zero}, {31'b0, m_a == m_b});
    chk("R9", "opcode", {25'b0, opcode}, {25'b0, m_ir[6:0]});
    chk("R9", "busy", {31'b0, busy}, {31'b0, mem_busy});
    chk("R10", "mem_we/re", {30'b0, mem_we, mem_re},
        {30'b0, (drv != 4) && mw, drv == 4});
    if (rwr && idx != 0) m_rf[idx] = exp_bus;
    if (lir) m_ir = exp_bus;
    if (la)  m_a  = exp_bus;
    if (lb)  m_b  = exp_bus;
    if (lma) m_ma = exp_bus;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 33; i++) m_rf[i] = '0;
    m_ir = '0; m_a = '0; m_b = '0; m_ma = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: reset state, program counter entry reads zero
    step("R1", 0, 0,0,0,0, 0,0,0,0, 0, 32'h0);
    step("R1", 3, 0,0,0,0, 4,0,0,0, 0, 32'h0);

    // R9: load IR from memory (rd=5 rs1=3 rs2=4)
    step("R9", 4, 1,0,0,0, 0,0,0,0, 0, enc(5,3,4,7'h55,0,7'h33));
    // R6 all immediate formats, R4 writes through rd/link/pc
    step("R6", 1, 0,0,0,0, 2,1,0,0, 0, 32'h0);
    step("R4", 3, 0,1,0,0, 2,0,0,0, 0, 32'h0);
    step("R6", 1, 0,0,1,0, 0,0,1,0, 0, 32'h0);
    step("R6", 1, 0,0,0,0, 3,1,2,0, 0, 32'h0);
    step("R6", 1, 0,0,0,0, 4,1,3,0, 0, 32'h0);
    step("R6", 4, 1,0,0,0, 0,0,0,0, 0, 32'hF821_8455);
    step("R6", 1, 0,0,0,0, 0,0,0,0, 0, 32'h0);
    step("R6", 1, 0,0,0,0, 0,0,1,0, 0, 32'h0);
    step("R6", 1, 0,0,0,0, 0,0,2,0, 0, 32'h0);
    step("R6", 1, 0,0,0,0, 0,0,3,0, 0, 32'h0);
    // R3/R4: MA, A <- PC in one cycle; PC <- A + 4 and A <- A - 4
    step("R4", 3, 0,1,0,1, 4,0,0,0, 0, 32'h0);
    step("R7", 2, 0,0,0,0, 4,1,0,3, 0, 32'h0);
    step("R4", 3, 0,0,0,0, 4,0,0,0, 0, 32'h0);
    step("R7", 2, 0,1,0,0, 0,0,0,2, 0, 32'h0);
    step("R7", 2, 0,0,0,0, 0,0,0,0, 0, 32'h0);
    // R4: link entry read back through rs1=1
    step("R4", 4, 1,0,0,0, 0,0,0,0, 0, enc(0,1,2,0,0,7'h6f));
    step("R4", 3, 0,0,0,0, 0,0,0,0, 0, 32'h0);
    step("R4", 3, 0,0,0,0, 3,0,0,0, 0, 32'h0);
    // R5: entry 0 reads zero, writes ignored
    step("R5", 4, 1,0,0,0, 0,0,0,0, 0, enc(0,0,0,7'h7f,0,7'h13));
    step("R5", 1, 0,0,0,0, 2,1,0,0, 0, 32'h0);
    step("R5", 3, 0,0,0,0, 2,0,0,0, 0, 32'h0);
    step("R5", 3, 0,0,0,0, 6,0,0,0, 0, 32'h0);
    // R8: equal and unequal operands
    step("R8", 4, 0,1,1,0, 0,0,0,0, 0, 32'h1234_5678);
    step("R8", 0, 0,0,0,0, 0,0,0,0, 0, 32'h0);
    step("R8", 4, 0,0,1,0, 0,0,0,0, 0, 32'h1234_5679);
    step("R8", 0, 0,0,0,0, 0,0,0,0, 0, 32'h0);
    // R7: every instruction-selected function, then A+B, B, and unused codes
    for (int fn = 0; fn < 8; fn++) begin
      step("R7", 4, 1,0,0,0, 0,0,0,0, 0, enc(1,2,3,7'h1a,fn,7'h33) | 32'h0020_0000);
      step("R7", 1, 0,1,0,0, 0,0,0,0, 0, 32'h0);
      step("R7", 4, 0,0,1,0, 0,0,0,0, 0, 32'hF0F0_0F35 + 32'(fn));
      step("R7", 2, 0,0,0,0, 0,0,0,4, 0, 32'h0);
    end
    for (int op = 0; op < 8; op++) step("R7", 2, 0,0,0,0, 0,0,0,op, 0, 32'h0);
    // R10: memory write of the bus, R2: idle bus
    step("R10", 2, 0,0,0,0, 0,0,0,0, 1, 32'hDEAD_BEEF);
    step("R2", 0, 0,0,0,0, 0,0,0,0, 1, 32'hDEAD_BEEF);
    step("R2", 0, 0,0,0,0, 0,0,0,0, 0, 32'hDEAD_BEEF);

    // R2/R3: random microinstructions, at most one driver
    for (int n = 0; n < 600; n++) begin
      int d;
      d = int'($urandom_range(0, 4));
      step("R2", d, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 7)), 1'($urandom), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 7)), (d != 4) && 1'($urandom), $urandom);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule